// File: doc/BRIEF.md
# SPI Configuration Programming Sequencer

This block loads a configuration image into a target device through the target's SPI slave port. A host starts a load by giving the image length. It then streams image bytes over a valid/ready handshake and finally asks for the load to be closed. The block works as the SPI master. It drives the serial clock, data out and an active-low chip select, and it samples the data returned by the target.

Before every command the block reads the target's status byte until the target can accept the command. It then walks through a fixed order of commands:
- the programming-enable command and a check of its four-byte result;
- the request to enter program mode;
- one frame command for every 16 image bytes;
- the programming-disable command;
- a settle delay;
- the release command.

The host sees busy, done and error flags, an error code, and a flag that is high while the target is in program mode. The serial bit engine and its clock divider are part of the block.

Top module: `spi_cfg_loader`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, and busy, done, error and prog_mode are 0, with err_code 0.
- R2: The serial link is mode 0 with the most significant bit first. sclk idles low. MOSI is stable around each rising edge, and the target's bit is sampled on that rising edge. Each sclk phase (high or low) lasts SCLK_DIV clock cycles.
- R3: A status poll sends 0x00 in two separate one-byte transfers, with cs_n returned high between them. Only the byte received in the second transfer is evaluated.
- R4: A poll succeeds when bit 0 (busy) of the status is 0 and all bits of the mask are 1. The mask is empty before a plain command and is bit 1 (ready) before the result read. A poll that does not succeed is repeated.
- R5: If status bit 2 or bit 3 is set, the load stops with error and err_code 2.
- R6: If a poll has not succeeded after TOUT_US microseconds, counted from the start of that poll, the load stops with error and err_code 4.
- R7: A load begins with command 0x0B. It follows with 0x01 and four read bytes under one chip select. Any non-zero read byte stops the load with err_code 3. Otherwise the block sends 0x0B and 0x01 ... then 0xAE followed by 0x01 under one chip select, and sets prog_mode.
- R8: Each group of 16 image bytes is sent as 0xEE followed by those bytes, in stream order, under one chip select, after its own poll. in_ready is high only while a byte can be taken, and only while prog_mode is 1.
- R9: A start whose img_len is not a multiple of 16 gives error with err_code 1 on the next cycle, and no chip-select activity.
- R10: The close sends 0x0C. It then waits at least SETTLE_US microseconds, and then sends 0x23. After that, prog_mode clears and done sets. A finish pulse given at any time during the load, including while the stream is still running, is remembered and honoured once all frames are sent.
- R11: busy is high from an accepted start until the load ends. done and error stay set until the next start and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a load (ignored while busy) |
| img_len | input | LEN_W | Image length in bytes, sampled with start |
| finish | input | 1 | Request to close the load |
| in_valid | input | 1 | Image byte valid |
| in_data | input | 8 | Image byte |
| in_ready | output | 1 | Block takes in_data this cycle when in_valid is set |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load completed |
| error | output | 1 | Load aborted |
| err_code | output | 3 | 0 none, 1 length, 2 status flag, 3 enable result, 4 timeout |
| prog_mode | output | 1 | Target is in program mode |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to target |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from target |

## Verification
The finish request and the final image byte can arrive in the same clock cycle. In that cycle the sequencer is still in the middle of a frame, so the request must be latched and not lost. The bench provokes this by raising finish in exactly the cycle where the last stream byte is accepted. It also covers finish given late and with an empty image. It judges each case by the full command order seen by its target model, ending in 0x0C and then 0x23, by the settle gap between those two commands, and by done being set with prog_mode cleared.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_LEN   = 3'd1,
    ERR_STAT  = 3'd2,
    ERR_ENRES = 3'd3,
    ERR_TOUT  = 3'd4
  } err_e;

  typedef enum logic [2:0] {
    STEP_EN, STEP_RD, STEP_PRG, STEP_FRM, STEP_DIS, STEP_REL
  } step_e;

  localparam logic [7:0] OP_STATUS  = 8'h00;
  localparam logic [7:0] OP_RDDATA  = 8'h01;
  localparam logic [7:0] OP_PGM_ON  = 8'h0B;
  localparam logic [7:0] OP_PGM_OFF = 8'h0C;
  localparam logic [7:0] OP_FINIT   = 8'hAE;
  localparam logic [7:0] OP_FRAME   = 8'hEE;
  localparam logic [7:0] OP_RELEASE = 8'h23;
  localparam logic [7:0] ARG_PRGMOD = 8'h01;

  localparam logic [7:0] ST_BUSY  = 8'h01;
  localparam logic [7:0] ST_READY = 8'h02;
endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic [7:0] tx,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; rx <= 8'h00; sclk <= 1'b0;
      mosi <= 1'b0; cnt <= '0; bitn <= 3'd0; sh <= 8'h00;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy <= 1'b1; sh <= tx; mosi <= tx[7];
          cnt <= '0; bitn <= 3'd0; sclk <= 1'b0;
        end
      end else if (cnt == CW'(DIV - 1)) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
            mosi <= sh[6];
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R2: the serial clock rests low whenever no byte is moving
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
  // R2: a byte ends only after a high phase, leaving the clock low
  p_done_low_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!sclk && !busy));
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int W          = 16,
  parameter int TOUT_CYC   = 1000,
  parameter int SETTLE_CYC = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tout_hit,
  output logic settle_hit
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + W'(1);
  end

  assign tout_hit   = (cnt >= W'(TOUT_CYC));
  assign settle_hit = (cnt >= W'(SETTLE_CYC));
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_loader_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic             finish,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       code_o,
  output logic             prog_o,
  output logic             cs_n,
  output logic             xreq,
  output logic [7:0]       xtx,
  input  logic             xbusy,
  input  logic             xdone,
  input  logic [7:0]       xrx,
  output logic             tmr_clr,
  input  logic             tout_hit,
  input  logic             settle_hit
);
  localparam int FW = LEN_W - 4;

  typedef enum logic [3:0] {
    S_IDLE, S_P1, S_PG, S_P2, S_PE, S_TB, S_TD, S_TE, S_FIN, S_SET
  } st_e;

  st_e          st;
  step_e        step;
  logic [4:0]   bcnt;
  logic [FW-1:0] frames_left;
  logic [7:0]   stat;
  logic         rd_nz;
  logic         fin_pend;

  logic [7:0] mask, opcode;
  logic [4:0] nbytes;

  always_comb begin
    mask   = (step == STEP_RD) ? ST_READY : 8'h00;
    nbytes = 5'd0;
    opcode = OP_RELEASE;
    case (step)
      STEP_EN:  opcode = OP_PGM_ON;
      STEP_RD:  begin opcode = OP_RDDATA; nbytes = 5'd4; end
      STEP_PRG: begin opcode = OP_FINIT;  nbytes = 5'd1; end
      STEP_FRM: begin opcode = OP_FRAME;  nbytes = 5'd16; end
      STEP_DIS: opcode = OP_PGM_OFF;
      default:  opcode = OP_RELEASE;
    endcase
  end

  assign in_ready = (st == S_TD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; step <= STEP_EN; bcnt <= '0; frames_left <= '0;
      stat <= 8'h00; rd_nz <= 1'b0; fin_pend <= 1'b0;
      busy_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0; code_o <= ERR_NONE;
      prog_o <= 1'b0; cs_n <= 1'b1; xreq <= 1'b0; xtx <= 8'h00; tmr_clr <= 1'b0;
    end else begin
      xreq    <= 1'b0;
      tmr_clr <= 1'b0;
      if (finish && st != S_IDLE) fin_pend <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          done_o <= 1'b0; err_o <= 1'b0; code_o <= ERR_NONE;
          fin_pend <= 1'b0; prog_o <= 1'b0;
          if (img_len[3:0] != 4'd0) begin
            err_o <= 1'b1; code_o <= ERR_LEN;
          end else begin
            busy_o <= 1'b1; frames_left <= img_len[LEN_W-1:4];
            step <= STEP_EN; tmr_clr <= 1'b1;
            cs_n <= 1'b0; xreq <= 1'b1; xtx <= OP_STATUS; st <= S_P1;
          end
        end
        S_P1: if (xdone) begin cs_n <= 1'b1; st <= S_PG; end
        S_PG: begin cs_n <= 1'b0; xreq <= 1'b1; xtx <= OP_STATUS; st <= S_P2; end
        S_P2: if (xdone) begin cs_n <= 1'b1; stat <= xrx; st <= S_PE; end
        S_PE: begin
          if (stat[3] || stat[2]) begin
            err_o <= 1'b1; code_o <= ERR_STAT; busy_o <= 1'b0; st <= S_IDLE;
          end else if ((stat & (ST_BUSY | mask)) == mask) begin
            cs_n <= 1'b0; xreq <= 1'b1; xtx <= opcode;
            bcnt <= '0; rd_nz <= 1'b0; st <= S_TB;
          end else if (tout_hit) begin
            err_o <= 1'b1; code_o <= ERR_TOUT; busy_o <= 1'b0; st <= S_IDLE;
          end else begin
            cs_n <= 1'b0; xreq <= 1'b1; xtx <= OP_STATUS; st <= S_P1;
          end
        end
        S_TB: if (xdone) begin
          if (step == STEP_RD && bcnt != 5'd0 && xrx != 8'h00) rd_nz <= 1'b1;
          if (bcnt == nbytes) begin
            cs_n <= 1'b1; st <= S_TE;
          end else begin
            bcnt <= bcnt + 5'd1;
            if (step == STEP_FRM) st <= S_TD;
            else begin
              xreq <= 1'b1;
              xtx  <= (step == STEP_PRG) ? ARG_PRGMOD : 8'h00;
            end
          end
        end
        S_TD: if (in_valid) begin xreq <= 1'b1; xtx <= in_data; st <= S_TB; end
        S_TE: begin
          case (step)
            STEP_EN: begin
              step <= STEP_RD; tmr_clr <= 1'b1;
              cs_n <= 1'b0; xreq <= 1'b1; xtx <= OP_STATUS; st <= S_P1;
            end
            STEP_RD: begin
              if (rd_nz) begin
                err_o <= 1'b1; code_o <= ERR_ENRES; busy_o <= 1'b0; st <= S_IDLE;
              end else begin
                step <= STEP_PRG; tmr_clr <= 1'b1;
                cs_n <= 1'b0; xreq <= 1'b1; xtx <= OP_STATUS; st <= S_P1;
              end
            end
            STEP_PRG: begin
              prog_o <= 1'b1;
              if (frames_left != '0) begin
                step <= STEP_FRM; tmr_clr <= 1'b1;
                cs_n <= 1'b0; xreq <= 1'b1; xtx <= OP_STATUS; st <= S_P1;
              end else st <= S_FIN;
            end
            STEP_FRM: begin
              frames_left <= frames_left - FW'(1);
              if (frames_left == FW'(1)) st <= S_FIN;
              else begin
                tmr_clr <= 1'b1;
                cs_n <= 1'b0; xreq <= 1'b1; xtx <= OP_STATUS; st <= S_P1;
              end
            end
            STEP_DIS: begin tmr_clr <= 1'b1; st <= S_SET; end
            default: begin
              prog_o <= 1'b0; done_o <= 1'b1; busy_o <= 1'b0; st <= S_IDLE;
            end
          endcase
        end
        S_FIN: if (fin_pend || finish) begin
          fin_pend <= 1'b0; step <= STEP_DIS; tmr_clr <= 1'b1;
          cs_n <= 1'b0; xreq <= 1'b1; xtx <= OP_STATUS; st <= S_P1;
        end
        S_SET: if (settle_hit && !tmr_clr) begin
          step <= STEP_REL; tmr_clr <= 1'b1;
          cs_n <= 1'b0; xreq <= 1'b1; xtx <= OP_STATUS; st <= S_P1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: every byte on the wire is framed by an asserted chip select
  p_cs_framed_r3: assert property (@(posedge clk) disable iff (rst)
    xbusy |-> !cs_n);
  // R8: image bytes are only taken while the target is in program mode
  p_ready_prog_r8: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> prog_o);
  // R11: completion and failure never show together
  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));
  // R9: a misaligned length fails on the following cycle
  p_len_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start && img_len[3:0] != 4'd0) |=> (err_o && code_o == ERR_LEN && cs_n));
  // R10: a finished load leaves program mode
  p_prog_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> !prog_o);
endmodule

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SCLK_DIV  = 2,
  parameter int TOUT_US   = 2_000_000,
  parameter int SETTLE_US = 1500,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic             finish,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [2:0]       err_code,
  output logic             prog_mode,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  input  logic             miso
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int TOUT_CYC   = CYC_PER_US * TOUT_US;
  localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
  localparam int TW         = $clog2(TOUT_CYC + SETTLE_CYC + 2);

  logic       xreq, xbusy, xdone, tmr_clr, tout_hit, settle_hit;
  logic [7:0] xtx, xrx;

  spi_byte_engine #(.DIV(SCLK_DIV)) u_eng (
    .clk(clk), .rst(rst), .req(xreq), .tx(xtx), .busy(xbusy), .done(xdone),
    .rx(xrx), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  cfg_timer #(.W(TW), .TOUT_CYC(TOUT_CYC), .SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tout_hit(tout_hit), .settle_hit(settle_hit)
  );

  cfg_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .img_len(img_len), .finish(finish),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .busy_o(busy), .done_o(done), .err_o(error), .code_o(err_code), .prog_o(prog_mode),
    .cs_n(cs_n), .xreq(xreq), .xtx(xtx), .xbusy(xbusy), .xdone(xdone), .xrx(xrx),
    .tmr_clr(tmr_clr), .tout_hit(tout_hit), .settle_hit(settle_hit)
  );
endmodule

// File: tb/spi_cfg_loader_tb.sv
module spi_cfg_loader_tb;
  localparam int DIV = 2;
  localparam int TOUT_CYC = 2000;
  localparam int SETTLE_CYC = 500;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, finish = 1'b0, in_valid = 1'b0;
  logic [15:0] img_len = '0;
  logic [7:0] in_data = '0;
  logic in_ready, busy, done, error, prog_mode, sclk, mosi, cs_n, miso;
  logic [2:0] err_code;

  always #5 clk = ~clk;

  spi_cfg_loader #(.CLK_HZ(100_000_000), .SCLK_DIV(DIV), .TOUT_US(20),
                   .SETTLE_US(5), .LEN_W(16)) u_dut (
    .clk(clk), .rst(rst), .start(start), .img_len(img_len), .finish(finish),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .busy(busy),
    .done(done), .error(error), .err_code(err_code), .prog_mode(prog_mode),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  // ---------------- target model ----------------
  int cyc = 0, hi_cnt = 0, last_hi = 0;
  always @(posedge clk) begin
    cyc++;
    if (sclk) hi_cnt++;
    else begin if (hi_cnt != 0) last_hi = hi_cnt; hi_cnt = 0; end
  end

  logic [7:0] st_val = 8'h02, opc = 8'hFF, prev_op = 8'hFF, sh_in = 8'h00, out_b = 8'h00, arg2 = 8'h00;
  logic [31:0] enres = 32'h0;
  int busy_until = 0, sreads = 0, bitc = 0, bytec = 0, n_cs = 0, cs_fall = 0;
  logic [7:0] op_log [0:511];
  logic [7:0] data_log [0:1023];
  int n_ops = 0, n_data = 0, frm_bad = 0, rd_bad = 0, stat_bad = 0, dis_end = 0, rel_start = 0;

  assign miso = cs_n ? 1'b0 : out_b[3'(7 - bitc)];

  always @(negedge cs_n or posedge sclk) begin
    if (!sclk) begin
      bitc = 0; bytec = 0; n_cs++; cs_fall = cyc;
      if (prev_op == 8'h00) begin
        out_b = (sreads < busy_until) ? 8'h01 : st_val;
        sreads++;
      end else out_b = 8'h0C;  // stale first read carries error flags
    end else if (!cs_n) begin
      sh_in = {sh_in[6:0], mosi};
      bitc++;
      if (bitc == 8) begin
        bitc = 0;
        if (bytec == 0) opc = sh_in;
        else if (opc == 8'hEE && n_data < 1024) begin data_log[n_data] = sh_in; n_data++; end
        if (opc == 8'hAE && bytec == 1) arg2 = sh_in;
        bytec++;
        out_b = (opc == 8'h01 && bytec >= 1 && bytec <= 4) ? enres[8*(bytec-1) +: 8] : 8'h00;
      end
    end
  end

  always @(posedge cs_n) begin
    if (bytec > 0) begin
      if (opc == 8'h00) begin
        if (bytec != 1) stat_bad++;
      end else begin
        if (n_ops < 512) begin op_log[n_ops] = opc; n_ops++; end
        if (opc == 8'hEE && bytec != 17) frm_bad++;
        if (opc == 8'h01 && bytec != 5) rd_bad++;
        if (opc == 8'h0C) dis_end = cyc;
        if (opc == 8'h23) rel_start = cs_fall;
      end
      prev_op = opc;
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_d [0:63];
  int base_ops, base_data;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_op(input int i, input int nfr);
    if (i == 0) return 8'h0B;
    if (i == 1) return 8'h01;
    if (i == 2) return 8'hAE;
    if (i < 3 + nfr) return 8'hEE;
    if (i == 3 + nfr) return 8'h0C;
    return 8'h23;
  endfunction

  task automatic run_img(input int nfr, input bit fin_early, input int bpolls,
                         input logic [7:0] sval, input logic [31:0] eres, output int el);
    int idx, guard, t0;
    bit fire, fin_sent;
    busy_until = sreads + bpolls; st_val = sval; enres = eres;
    for (int k = 0; k < 64; k++) exp_d[k] = 8'($urandom);
    base_ops = n_ops; base_data = n_data;
    @(negedge clk); img_len = 16'(nfr * 16); start = 1'b1;
    @(negedge clk); start = 1'b0; t0 = cyc;
    idx = 0; fire = 0; fin_sent = 0; guard = 0;
    while (!(done || error) && guard < 60000) begin
      @(negedge clk); guard++;
      finish = 1'b0;
      if (fire) idx++;
      in_valid = (idx < nfr * 16) && ($urandom % 4 != 0);
      in_data = exp_d[idx % 64];
      fire = in_valid && in_ready;
      if (fin_early && !fin_sent && fire && idx == nfr * 16 - 1) begin
        finish = 1'b1; fin_sent = 1;   // same cycle as last byte accepted
      end
      if (!fin_early && !fin_sent && idx == nfr * 16 && prog_mode && !in_ready) begin
        chk(prog_mode == 1'b1, "R7 prog_mode set before close", prog_mode, 1);
        finish = 1'b1; fin_sent = 1;
      end
    end
    in_valid = 1'b0; finish = 1'b0;
    el = cyc - t0;
  endtask

  task automatic check_good(input int nfr);
    chk(done == 1'b1, "R10 done", done, 1);
    chk(error == 1'b0, "R11 no error", error, 0);
    chk(busy == 1'b0 && prog_mode == 1'b0, "R10 idle and prog cleared", {busy, prog_mode}, 0);
    chk(n_ops - base_ops == 5 + nfr, "R7 command count", n_ops - base_ops, 5 + nfr);
    for (int i = 0; i < 5 + nfr && i < n_ops - base_ops; i++)
      chk(op_log[base_ops + i] == exp_op(i, nfr), "R7 command order", op_log[base_ops + i], exp_op(i, nfr));
    chk(n_data - base_data == nfr * 16, "R8 byte count", n_data - base_data, nfr * 16);
    for (int i = 0; i < nfr * 16 && i < n_data - base_data; i++)
      chk(data_log[base_data + i] == exp_d[i % 64], "R8 data order", data_log[base_data + i], exp_d[i % 64]);
    chk(frm_bad == 0 && rd_bad == 0, "R8 frame and read lengths", frm_bad + rd_bad, 0);
    chk(stat_bad == 0, "R3 one-byte status transfers", stat_bad, 0);
    chk(arg2 == 8'h01, "R7 program-mode argument", arg2, 1);
    chk(rel_start - dis_end >= SETTLE_CYC && rel_start - dis_end <= 2 * SETTLE_CYC,
        "R10 settle gap", rel_start - dis_end, SETTLE_CYC);
    chk(last_hi == DIV, "R2 sclk high phase", last_hi, DIV);
  endtask

  initial begin
    int el, s, nfr, ncs0;
    s = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 bus idle", {cs_n, sclk}, 2);
    chk({busy, done, error, prog_mode, err_code} == 7'd0, "R1 flags clear",
        {busy, done, error, prog_mode, err_code}, 0);

    // R9 misaligned length
    ncs0 = n_cs;
    @(negedge clk); img_len = 16'd20; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(error == 1'b1 && err_code == 3'd1, "R9 length error code", err_code, 1);
    repeat (20) @(negedge clk);
    chk(n_cs == ncs0, "R9 no chip select activity", n_cs - ncs0, 0);

    // directed: empty image, then finish/last-byte collision (R10)
    run_img(0, 0, 0, 8'h02, 32'h0, el); check_good(0);
    run_img(3, 1, 2, 8'h02, 32'h0, el); check_good(3);

    // random loads; first read of each poll is stale (R3), busy retries (R4)
    for (int r = 0; r < 5; r++) begin
      nfr = int'($urandom % 4);
      run_img(nfr, (nfr > 0) && ($urandom % 2 == 1), int'($urandom % 4), 8'h02, 32'h0, el);
      check_good(nfr);
    end

    // R5 status flag
    run_img(1, 0, 0, 8'h06, 32'h0, el);
    chk(error == 1'b1 && err_code == 3'd2, "R5 status flag bit2", err_code, 2);
    run_img(1, 0, 1, 8'h0A, 32'h0, el);
    chk(error == 1'b1 && err_code == 3'd2, "R5 status flag bit3", err_code, 2);
    chk(n_ops == base_ops, "R5 no command sent", n_ops - base_ops, 0);

    // R6 timeout with target busy forever
    run_img(1, 0, 100000, 8'h02, 32'h0, el);
    chk(error == 1'b1 && err_code == 3'd4, "R6 timeout code", err_code, 4);
    chk(el >= TOUT_CYC, "R6 timeout not early", el, TOUT_CYC);
    chk(busy == 1'b0 && done == 1'b0, "R11 idle after abort", {busy, done}, 0);

    // R4 ready mask: not busy, not ready -> enable goes out, result read never does
    run_img(1, 0, 0, 8'h00, 32'h0, el);
    chk(err_code == 3'd4, "R4 ready mask timeout", err_code, 4);
    chk(n_ops - base_ops == 1 && op_log[base_ops] == 8'h0B, "R4 only enable sent",
        n_ops - base_ops, 1);

    // R7 non-zero enable result
    run_img(2, 0, 0, 8'h02, 32'h0000_0100, el);
    chk(error == 1'b1 && err_code == 3'd3, "R7 result failure code", err_code, 3);
    chk(n_ops - base_ops == 2 && prog_mode == 1'b0, "R7 stops before program mode",
        n_ops - base_ops, 2);

    // recovery after errors
    run_img(1, 0, 1, 8'h02, 32'h0, el); check_good(1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule